// File: doc/BRIEF.md
# Echo-Request Reload Trigger

This block watches the byte stream of received Ethernet frames. Each byte arrives with a valid strobe, a start-of-frame mark, an end-of-frame mark and an error flag. The block looks for one kind of frame: an IPv4 ICMP echo request sent to the local IP address whose payload opens with the node's own 16-bit network address. When such a frame ends cleanly, the block raises a request to reload the configuration of the FPGA that received it. The request stays high until the reload logic acknowledges it.

The block needs nothing but the received stream and two configuration words. It therefore still works when the on-chip data network or the slow-control path has hung, and an operator can recover the node by sending one ping. The block never builds or sends an echo reply, so a reply path that is blocked cannot prevent the trigger.

Byte positions count from 0 at the first destination-MAC byte, which is the beat marked by `rx_sof`. No preamble is present, and the IPv4 header is assumed to carry no options.

Top module: `ping_reload_trigger`

## Requirements
- R1: A synchronous active-high `rst` clears `reload_req` and the parser state. A frame that was partly received before reset never fires.
- R2: `reload_req` rises on the clock edge after the end-of-frame beat of a frame in which all of the following hold:
  - bytes 12..13 are 0x08,0x00;
  - byte 14 is 0x45;
  - byte 23 is 0x01;
  - bytes 30..33 equal `local_ip`, most significant byte first;
  - byte 34 is 0x08 and byte 35 is 0x00;
  - byte 42 equals `node_addr[15:8]` and byte 43 equals `node_addr[7:0]`.
- R3: All other bytes (MAC addresses, the other IPv4 fields, the ICMP checksum, identifier and sequence number) have no influence. A wrong value at any position listed in R2 prevents the request.
- R4: A frame whose end-of-frame beat comes before byte 43 never fires. A frame that ends on byte 43, or later (for example with the address pattern repeated), can fire.
- R5: When `rx_err` is high on the end-of-frame beat, the frame does not fire.
- R6: Once high, `reload_req` stays high until `reload_ack` is sampled high. It is low on the edge after that sample. `reload_ack` has no effect while `reload_req` is low.
- R7: A qualifying frame that ends while `reload_req` is high is ignored. It leaves no request behind after the acknowledge.
- R8: Cycles with `rx_valid` low are ignored and do not advance the byte position. Valid bytes that arrive after an end-of-frame and before the next start-of-frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_sof | input | 1 | This beat is byte 0 of a frame |
| rx_eof | input | 1 | This beat is the last byte of a frame |
| rx_err | input | 1 | Frame flagged bad; sampled on the end-of-frame beat |
| local_ip | input | 32 | Local IPv4 address |
| node_addr | input | 16 | Node network address expected in the payload |
| reload_ack | input | 1 | Clears a pending request |
| reload_req | output | 1 | Pending reload request |

## Verification
The bench first flips one bit in each of the first 44 bytes of a good frame, one position at a time. The expected outcome follows from whether that position is one the block checks, which separates the checked fields from the ignored ones.

A length sweep ends frames at every length from 30 to 50 bytes, which locates the shortest frame that can fire. Several node addresses are then tried, each with its payload bytes in the correct order and in swapped order, which separates a true byte-order match from a mere equality of the two bytes.

Further frames carry an error flag, valid-low bubbles, stray bytes outside a frame, a second match during a pending request, and a reset in mid-frame. These show that the flag blocks the trigger, that bubbles and stray bytes are ignored, that the request is held until acknowledged and not repeated, and that reset drops a partial frame.

// File: rtl/ping_reload_trigger.sv
module ping_reload_trigger (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic [31:0] local_ip,
  input  logic [15:0] node_addr,
  input  logic        reload_ack,
  output logic        reload_req
);
  localparam int PW       = 6;
  localparam int LAST_POS = 43;
  localparam logic [PW-1:0] POS_MAX = {PW{1'b1}};

  logic [PW-1:0] idx;
  logic          in_frm, ok, hit;

  wire          beat  = rx_valid & (rx_sof | in_frm);
  wire [PW-1:0] pos   = rx_sof ? '0 : idx;
  wire          ok_nx = (rx_sof | ok) & hit;
  wire          fire  = beat & rx_eof & ok_nx & ~rx_err & (pos >= PW'(LAST_POS));

  always_comb begin
    case (pos)
      6'd12:   hit = rx_data == 8'h08;
      6'd13:   hit = rx_data == 8'h00;
      6'd14:   hit = rx_data == 8'h45;
      6'd23:   hit = rx_data == 8'h01;
      6'd30:   hit = rx_data == local_ip[31:24];
      6'd31:   hit = rx_data == local_ip[23:16];
      6'd32:   hit = rx_data == local_ip[15:8];
      6'd33:   hit = rx_data == local_ip[7:0];
      6'd34:   hit = rx_data == 8'h08;
      6'd35:   hit = rx_data == 8'h00;
      6'd42:   hit = rx_data == node_addr[15:8];
      6'd43:   hit = rx_data == node_addr[7:0];
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      in_frm     <= 1'b0;
      ok         <= 1'b0;
      reload_req <= 1'b0;
    end else begin
      if (beat) begin
        idx    <= (pos == POS_MAX) ? POS_MAX : pos + 1'b1;
        ok     <= ok_nx;
        in_frm <= ~rx_eof;
      end
      reload_req <= (reload_req & ~reload_ack) | (fire & ~reload_req);
    end
  end
endmodule

module ping_reload_trigger_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_eof,
  input logic rx_err,
  input logic reload_ack,
  input logic reload_req
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !reload_req);
  assert_rise_on_eof_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(reload_req) |-> $past(rx_valid && rx_eof));
  assert_err_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(reload_req) |-> !$past(rx_err));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (reload_req && !reload_ack) |=> reload_req);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (reload_req && reload_ack) |=> !reload_req);
endmodule

bind ping_reload_trigger ping_reload_trigger_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .rx_err(rx_err), .reload_ack(reload_ack), .reload_req(reload_req)
);

// File: tb/sim_ping_reload_trigger.sv
`timescale 1ns/1ps
module sim_ping_reload_trigger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [31:0] local_ip = 32'hC0A8_0A21;
  logic [15:0] node_addr = 16'hC001;
  logic        reload_ack = 1'b0;
  logic        reload_req;

  int total = 0, bad = 0;
  logic [7:0] fr [0:63];

  always #2.5 clk = ~clk;

  ping_reload_trigger u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .local_ip(local_ip),
    .node_addr(node_addr), .reload_ack(reload_ack), .reload_req(reload_req)
  );

  task automatic check(input logic exp, input string tag);
    total++;
    if (reload_req !== exp) begin
      bad++;
      $display("FAIL %s: reload_req=%0b expected=%0b", tag, reload_req, exp);
    end
  endtask

  task automatic build();
    for (int i = 0; i < 64; i++) fr[i] = 8'(i * 7 + 3);
    fr[12] = 8'h08; fr[13] = 8'h00; fr[14] = 8'h45; fr[23] = 8'h01;
    fr[30] = local_ip[31:24]; fr[31] = local_ip[23:16];
    fr[32] = local_ip[15:8];  fr[33] = local_ip[7:0];
    fr[34] = 8'h08; fr[35] = 8'h00;
    for (int i = 42; i < 64; i += 2) begin
      fr[i] = node_addr[15:8]; fr[i+1] = node_addr[7:0];
    end
  endtask

  task automatic send(input int len, input logic err, input logic gaps, input logic sof_on);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk); rx_valid = 1'b0; rx_data = 8'h45; rx_sof = 1'b0; rx_eof = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fr[i];
      rx_sof = sof_on && (i == 0);
      rx_eof = (i == len - 1);
      rx_err = err && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  task automatic ack_it(input string tag);
    reload_ack = 1'b1;
    @(negedge clk); reload_ack = 1'b0;
    check(1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset state");
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 idle after reset");

    build();
    send(44, 1'b0, 1'b0, 1'b1);
    check(1'b1, "R2 good frame");
    ack_it("R6 ack clears");

    for (int p = 0; p < 44; p++) begin
      logic exp;
      exp = !(p == 12 || p == 13 || p == 14 || p == 23 ||
              (p >= 30 && p <= 35) || p == 42 || p == 43);
      build();
      fr[p] = fr[p] ^ 8'h10;
      send(48, 1'b0, 1'b0, 1'b1);
      check(exp, $sformatf("R3 corrupt byte %0d", p));
      if (exp) ack_it("R6 ack after R3 case");
    end

    build();
    for (int len = 30; len <= 50; len++) begin
      send(len, 1'b0, 1'b0, 1'b1);
      check(len >= 44, $sformatf("R4 length %0d", len));
      if (len >= 44) ack_it("R6 ack after R4 case");
    end

    for (int k = 0; k < 5; k++) begin
      logic [15:0] a;
      a = (k == 0) ? 16'hC001 : (k == 1) ? 16'hF3C0 : (k == 2) ? 16'h0000 :
          (k == 3) ? 16'hFFFF : 16'h1234;
      node_addr = a;
      build();
      send(60, 1'b0, 1'b0, 1'b1);
      check(1'b1, $sformatf("R2 addr %h repeated payload", a));
      ack_it("R6 ack after addr");
      fr[42] = a[7:0]; fr[43] = a[15:8];
      send(44, 1'b0, 1'b0, 1'b1);
      check(a[15:8] == a[7:0], $sformatf("R2 addr %h swapped bytes", a));
      if (a[15:8] == a[7:0]) ack_it("R6 ack after swap");
    end
    node_addr = 16'hC001;
    build();

    send(44, 1'b1, 1'b0, 1'b1);
    check(1'b0, "R5 error flag blocks");

    send(44, 1'b0, 1'b1, 1'b1);
    check(1'b1, "R8 valid-low bubbles ignored");
    ack_it("R6 ack after bubbles");

    send(44, 1'b0, 1'b0, 1'b0);
    check(1'b0, "R8 bytes outside frame ignored");

    reload_ack = 1'b1;
    @(negedge clk); reload_ack = 1'b0;
    check(1'b0, "R6 ack while idle no effect");

    send(44, 1'b0, 1'b0, 1'b1);
    check(1'b1, "R7 first match");
    send(44, 1'b0, 1'b0, 1'b1);
    check(1'b1, "R7 second match while pending");
    repeat (5) @(negedge clk);
    check(1'b1, "R6 held without ack");
    ack_it("R7 ack");
    repeat (3) @(negedge clk);
    check(1'b0, "R7 no leftover request");

    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = fr[i]; rx_sof = (i == 0);
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 20; i < 44; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = fr[i]; rx_eof = (i == 43);
    end
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    check(1'b0, "R1 reset drops partial frame");

    send(44, 1'b0, 1'b0, 1'b1);
    check(1'b1, "R1 frame after reset");
    ack_it("R6 final ack");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: done=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule